// File: doc/BRIEF.md
# Age-Counter Replacement Tracker for an 8-Way Cache

This block keeps the replacement order for every set of an eight-way set-associative cache. Each way of each set owns a small age counter. Age 0 marks the way used most recently, and the largest age marks the way unused for the longest time. Together the eight ages of a set always form an ordering of 0 to 7. Tags and data live elsewhere. The cache controller presents a set index with an access strobe, and says whether the lookup hit and, if so, in which way.

On a hit, the named way becomes the youngest. Only the ways that were younger than it age by one, so the full order is kept exactly. On a miss, the block names the oldest way as the victim. That way is taken as refilled and becomes the youngest, and every other way in the set ages by one. The victim output is purely combinational from the indexed set. The controller can therefore read it in the same cycle it presents the set index, before it commits the access.

Top module: `lru_tracker`

## Requirements
- R1: After reset, the ages of every set are equal to their way numbers, so the victim reported for any set is way 7.
- R2: `victim_way` is, in the same cycle, the way whose age is largest in the set selected by `acc_set`.
- R3: After an access, the way that was used (the hit way, or the victim on a miss) has age 0 and is not the victim of that set in the next cycle.
- R4: On a hit (`acc_valid`=1, `acc_hit`=1), ways younger than the hit way age by one and older ways keep their age. Example: after reset, a hit on way 2 followed by misses gives the victims 7,6,5,4,3,1,0,2 in that order.
- R5: On a miss (`acc_valid`=1, `acc_hit`=0), the reported victim becomes age 0, all other ways of the set age by one, and `acc_way` is ignored. Example: after reset, one miss changes the victim of that set from 7 to 6.
- R6: The eight ages of every set always form an ordering of 0 to 7, with no value repeated.
- R7: While `acc_valid` is 0, no age changes, whatever `acc_hit` and `acc_way` hold.
- R8: An access changes only the set given by `acc_set`; the victims of all other sets are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access to set `acc_set` is committed this cycle |
| acc_set | input | SET_W (4) | Set index of the access, also selects the victim shown |
| acc_hit | input | 1 | 1: the access hit in `acc_way`; 0: miss, the victim is refilled |
| acc_way | input | WAY_W (3) | Way that hit; ignored on a miss |
| victim_way | output | WAY_W (3) | Oldest way of the set selected by `acc_set` |

## Verification
Directed sequences pin down exact orders: the reset state across all sets, a run of misses alone, which must walk down through the ways 7, 6, 5 and onward, and a hit in the middle of the order followed by misses. That second sequence tells the partial ageing of a hit apart from ageing every way. Strobe-low cycles with random hit and way values, and scans of all sets after accesses to one set, show whether anything leaks into idle cycles or other sets. A long random stream, with mostly hits concentrated on a few sets, is compared each cycle against a per-set age model held in the bench. It reaches orders that the directed cases do not.

// File: rtl/lru_pkg.sv
package lru_pkg;

    // Kind of access committed by the cache controller
    typedef enum logic {
        ACC_MISS = 1'b0,
        ACC_HIT  = 1'b1
    } acc_kind_e;

    // Default organisation
    localparam int unsigned DEF_WAYS = 8;
    localparam int unsigned DEF_SETS = 16;

endpackage

// File: rtl/lru_victim_sel.sv
module lru_victim_sel #(
    parameter int unsigned WAYS  = 8,
    parameter int unsigned WAY_W = $clog2(WAYS),
    parameter int unsigned AGE_W = WAY_W
) (
    input  logic [WAYS-1:0][AGE_W-1:0] row,
    output logic [WAY_W-1:0]           oldest
);

    // Scan the row; the lowest index wins a tie (ties cannot occur in a
    // legal permutation, the rule only keeps the choice deterministic).
    always_comb begin
        oldest = '0;
        for (int w = 1; w < int'(WAYS); w++) begin
            if (row[w] > row[oldest]) begin
                oldest = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/lru_age_update.sv
module lru_age_update #(
    parameter int unsigned WAYS  = 8,
    parameter int unsigned WAY_W = $clog2(WAYS),
    parameter int unsigned AGE_W = WAY_W
) (
    input  logic [WAYS-1:0][AGE_W-1:0] row,
    input  logic [WAY_W-1:0]           used_way,
    output logic [WAYS-1:0][AGE_W-1:0] row_next
);

    logic [AGE_W-1:0] used_age;

    assign used_age = row[used_way];

    // One ageing cell per way: the used way becomes youngest, ways that
    // were younger than it move back by one, older ways hold.
    for (genvar w = 0; w < int'(WAYS); w++) begin : g_way
        logic is_used;
        logic younger;

        assign is_used = (used_way == WAY_W'(w));
        assign younger = (row[w] < used_age);

        always_comb begin
            if (is_used) begin
                row_next[w] = '0;
            end else if (younger) begin
                row_next[w] = row[w] + AGE_W'(1);
            end else begin
                row_next[w] = row[w];
            end
        end
    end

endmodule

// File: rtl/lru_tracker.sv
module lru_tracker #(
    parameter int unsigned NUM_SETS = lru_pkg::DEF_SETS,
    parameter int unsigned WAYS     = lru_pkg::DEF_WAYS,
    parameter int unsigned SET_W    = $clog2(NUM_SETS),
    parameter int unsigned WAY_W    = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic             acc_hit,
    input  logic [WAY_W-1:0] acc_way,
    output logic [WAY_W-1:0] victim_way
);

    import lru_pkg::*;

    localparam int unsigned AGE_W = WAY_W;

    typedef logic [WAYS-1:0][AGE_W-1:0] row_t;

    typedef struct packed {
        logic [NUM_SETS-1:0][WAYS-1:0][AGE_W-1:0] age;
    } state_t;

    state_t     st_d, st_q;
    row_t       cur_row;
    row_t       new_row;
    logic [WAY_W-1:0] oldest_way;
    logic [WAY_W-1:0] used_way;
    acc_kind_e  kind;

    assign cur_row = st_q.age[acc_set];
    assign kind    = acc_kind_e'(acc_hit);

    lru_victim_sel #(
        .WAYS  (WAYS),
        .WAY_W (WAY_W),
        .AGE_W (AGE_W)
    ) u_sel (
        .row    (cur_row),
        .oldest (oldest_way)
    );

    assign used_way = (kind == ACC_HIT) ? acc_way : oldest_way;

    lru_age_update #(
        .WAYS  (WAYS),
        .WAY_W (WAY_W),
        .AGE_W (AGE_W)
    ) u_upd (
        .row      (cur_row),
        .used_way (used_way),
        .row_next (new_row)
    );

    assign victim_way = oldest_way;

    always_comb begin
        st_d = st_q;
        if (acc_valid) begin
            st_d.age[acc_set] = new_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(NUM_SETS); s++) begin
                for (int w = 0; w < int'(WAYS); w++) begin
                    st_q.age[s][w] <= AGE_W'(w);
                end
            end
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lru_tracker_chk.sv
module lru_tracker_chk #(
    parameter int unsigned NUM_SETS = 16,
    parameter int unsigned WAYS     = 8,
    parameter int unsigned SET_W    = $clog2(NUM_SETS),
    parameter int unsigned WAY_W    = $clog2(WAYS)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         acc_valid,
    input logic [SET_W-1:0]             acc_set,
    input logic                         acc_hit,
    input logic [WAY_W-1:0]             acc_way,
    input logic [WAY_W-1:0]             victim_way,
    input logic [WAYS-1:0][WAY_W-1:0]   cur_row
);

    logic             past_ok;
    logic [WAYS-1:0]  seen;
    logic [WAY_W-1:0] used;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb begin
        seen = '0;
        for (int w = 0; w < int'(WAYS); w++) begin
            seen[cur_row[w]] = 1'b1;
        end
    end

    assign used = acc_hit ? acc_way : victim_way;

    AST_RESET_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        !past_ok |-> victim_way == WAY_W'(WAYS-1)); // R1

    AST_VICTIM_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        cur_row[victim_way] == WAY_W'(WAYS-1)); // R2

    AST_USED_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(acc_valid) && acc_set == $past(acc_set)
        |-> victim_way != $past(used)); // R3

    AST_AGE_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        &seen); // R6

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(acc_valid) && acc_set == $past(acc_set)
        |-> victim_way == $past(victim_way)); // R7

endmodule

bind lru_tracker lru_tracker_chk #(
    .NUM_SETS (NUM_SETS),
    .WAYS     (WAYS),
    .SET_W    (SET_W),
    .WAY_W    (WAY_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_set    (acc_set),
    .acc_hit    (acc_hit),
    .acc_way    (acc_way),
    .victim_way (victim_way),
    .cur_row    (cur_row)
);

// File: tb/lru_tracker_tb.sv
module lru_tracker_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NSETS      = 16;
    localparam int NWAYS      = 8;
    localparam int SW         = 4;
    localparam int WW         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [SW-1:0] acc_set = '0;
    logic          acc_hit = 1'b0;
    logic [WW-1:0] acc_way = '0;
    logic [WW-1:0] victim_way;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int model [NSETS][NWAYS];

    always #(CLK_PERIOD/2) clk = ~clk;

    lru_tracker u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_set    (acc_set),
        .acc_hit    (acc_hit),
        .acc_way    (acc_way),
        .victim_way (victim_way)
    );

    function automatic int model_victim(int s);
        int best = 0;
        for (int w = 1; w < NWAYS; w++) if (model[s][w] > model[s][best]) best = w;
        return best;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle; check the combinational victim before the edge,
    // then advance the model as the edge commits the access.
    task automatic step(bit v, int s, bit h, int w, string req);
        int used, old;
        @(negedge clk);
        acc_valid = v; acc_set = SW'(s); acc_hit = h; acc_way = WW'(w);
        #1;
        check(req, int'(victim_way), model_victim(s));
        if (v) begin
            used = h ? w : model_victim(s);
            old  = model[s][used];
            for (int k = 0; k < NWAYS; k++) begin
                if (k == used) model[s][k] = 0;
                else if (model[s][k] < old) model[s][k]++;
            end
        end
    endtask

    task automatic scan(string req);
        for (int s = 0; s < NSETS; s++) step(1'b0, s, 1'($urandom), int'($urandom_range(0, 7)), req);
    endtask

    task automatic expect_victim(int s, int exp, string req);
        @(negedge clk);
        acc_valid = 1'b0; acc_set = SW'(s);
        #1;
        check(req, int'(victim_way), exp);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < NWAYS; w++) model[s][w] = w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every set reports way 7 after reset
        for (int s = 0; s < NSETS; s++) expect_victim(s, 7, "R1");

        // R3: hitting the oldest way moves the victim to way 6
        step(1'b1, 1, 1'b1, 7, "R3");
        expect_victim(1, 6, "R3");

        // R5: one miss, acc_way garbage ignored, victim goes 7 -> 6
        step(1'b1, 3, 1'b0, 2, "R5");
        expect_victim(3, 6, "R5");
        step(1'b1, 3, 1'b0, 6, "R5");
        expect_victim(3, 5, "R5");

        // R4: hit on way 2 then a run of misses
        step(1'b1, 4, 1'b1, 2, "R4");
        begin
            int exp_seq [8] = '{7, 6, 5, 4, 3, 1, 0, 2};
            for (int i = 0; i < 8; i++) begin
                expect_victim(4, exp_seq[i], "R4");
                step(1'b1, 4, 1'b0, int'($urandom_range(0, 7)), "R4");
            end
        end

        // R7: strobe low with random hit/way, nothing may move
        for (int i = 0; i < 20; i++)
            step(1'b0, int'($urandom_range(0, 3)), 1'($urandom), int'($urandom_range(0, 7)), "R7");
        scan("R7");

        // R8: hammer set 0, other sets must keep their victims
        for (int i = 0; i < 30; i++)
            step(1'b1, 0, 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)), "R8");
        scan("R8");

        // R2 R6: random stream against the model
        for (int i = 0; i < 4000; i++) begin
            int s = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, NSETS-1))
                                                : int'($urandom_range(0, 2));
            bit v = ($urandom_range(0, 7) != 0);
            bit h = ($urandom_range(0, 4) != 0);
            step(v, s, h, int'($urandom_range(0, 7)), "R2");
        end
        scan("R6");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule